// File: doc/BRIEF.md
# Memory-ordering load/store queue scheduler

This block sits between the dispatch stage and the memory pipelines of an out-of-order core. Each memory instruction is presented on the dispatch port in program order, together with three flags: it reads memory, it writes memory, and it has side effects that cannot be reasoned about. The block checks that the queues it needs have room. If they do, it accepts the instruction, hands it the next age tag and records it in a load queue, a store queue, or both. If they do not, it raises a stall and the instruction must be presented again.

Each cycle the block picks the oldest load and the oldest store that the ordering rules allow to start, and presents their tags on two issue ports. An issued entry then waits for its tag to come back on the completion port. A side-effect flag turns the entry into a barrier. A barrier never issues. It retires by itself once it is the oldest entry in every queue it occupies, and until then it holds back younger operations of its own kind. A mode input selects whether loads may run ahead of older stores, which is safe only when the two never touch the same address.

Each queue slot is a small state machine with four named states: FREE (empty), WAIT (allocated, not started), ISSUED (started, waiting for completion) and DONE (finished, waiting to be released). The transitions are: alloc (FREE to WAIT, at the tail), issue (WAIT to ISSUED, when picked), barrier-retire (WAIT to DONE, barrier at the head), complete (ISSUED to DONE, on a tag match) and release (DONE to FREE, only at the head).

Top module: `lsq_sched`

## Requirements
- R1: After reset both queues are empty, no issue port is valid, the stall output is low and the offered tag is 0.
- R2: The stall output is high exactly when dispatch is valid and a needed queue is full. A read needs the load queue and a write needs the store queue. A stalled attempt allocates nothing and consumes no tag.
- R3: Loads that have no store or barrier between them issue one per cycle, oldest first, without waiting for older loads to complete.
- R4: A load may not issue while an older load is still waiting and a store or barrier that has not started lies between the two in program order.
- R5: A store issues only after every older store has issued and every older store-queue barrier has retired.
- R6: A store issues only after every older load has issued, in both alias modes.
- R7: With the no-alias input low, a load waits until every older store has issued. With it high, older stores do not hold a load back.
- R8: A read with side effects is a load barrier and takes one load-queue entry. A write with side effects is a store barrier and takes one store-queue entry. A read-write with side effects is a full barrier and takes one entry in each queue. A read-write without side effects takes one operation entry in each queue.
- R9: A barrier retires only when it is at the head of every queue it occupies, both halves of a full barrier in the same cycle. While it waits, younger entries of its own queue kind do not issue.
- R10: Each issue port shows the tag of the oldest eligible entry of its queue. That entry moves to the issued state at the next clock edge and is never shown twice.
- R11: A completion tag marks a matching issued entry done in any order, and a completion that matches no issued entry has no effect. Entries are released only from the head, one per queue per cycle.
- R12: Tags count up by one per accepted dispatch, modulo 2^TAG_W. Age comparisons use the wrap-safe difference, so they stay correct across the wrap as long as live tags span less than half the tag range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| no_alias_en | input | 1 | High lets loads issue ahead of older stores |
| disp_valid | input | 1 | Dispatch attempt this cycle |
| disp_rd | input | 1 | Instruction reads memory |
| disp_wr | input | 1 | Instruction writes memory |
| disp_fx | input | 1 | Instruction has side effects |
| disp_stall | output | 1 | Attempt refused for lack of queue room |
| disp_tag | output | TAG_W | Tag given to the instruction if accepted |
| ld_issue_valid | output | 1 | A load is issued this cycle |
| ld_issue_tag | output | TAG_W | Tag of the issued load |
| st_issue_valid | output | 1 | A store is issued this cycle |
| st_issue_tag | output | TAG_W | Tag of the issued store |
| exec_valid | input | 1 | A memory operation finished |
| exec_tag | input | TAG_W | Tag of the finished operation |

## Verification
The bench builds the block with a four-entry load queue, a three-entry store queue and 6-bit tags. Both queues fill after a handful of dispatches, so stalls, barriers stuck behind uncompleted heads, and long chains of blocked loads and stores happen often. The tag counter wraps every 64 accepted dispatches, so the wrap-safe age comparison is crossed many times. Sweeps cover every flag combination in both alias modes, with completion rates that range from sparse to immediate. A reference model keeps both queues as lists in age order and predicts every output each cycle.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    // Life cycle of one queue slot.
    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_WAIT   = 2'd1,
        SLOT_ISSUED = 2'd2,
        SLOT_DONE   = 2'd3
    } slot_state_e;

endpackage

// File: rtl/lsq_ring.sv
module lsq_ring
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic [TAG_W-1:0] alloc_tag_i,
    input  logic             alloc_bar_i,
    input  logic             issue_i,
    input  logic [IDX_W-1:0] issue_idx_i,
    input  logic             bar_exec_i,
    input  logic             cpl_i,
    input  logic [TAG_W-1:0] cpl_tag_i,
    output slot_state_e      state_o [DEPTH],
    output logic [TAG_W-1:0] tag_o   [DEPTH],
    output logic             bar_o   [DEPTH],
    output logic [IDX_W-1:0] head_o,
    output logic             full_o,
    output logic [CNT_W-1:0] count_o
);

    slot_state_e      st_q  [DEPTH];
    slot_state_e      st_d  [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic             bar_q [DEPTH];
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pop;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // The head is released once it has finished.
    assign pop = (st_q[head_q] == SLOT_DONE);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_comb begin
            st_d[i] = st_q[i];
            unique case (st_q[i])
                SLOT_FREE: begin
                    if (alloc_i && tail_q == IDX_W'(i)) st_d[i] = SLOT_WAIT;
                end
                SLOT_WAIT: begin
                    if (issue_i && issue_idx_i == IDX_W'(i))
                        st_d[i] = SLOT_ISSUED;
                    else if (bar_exec_i && head_q == IDX_W'(i))
                        st_d[i] = SLOT_DONE;
                end
                SLOT_ISSUED: begin
                    if (cpl_i && tag_q[i] == cpl_tag_i) st_d[i] = SLOT_DONE;
                end
                SLOT_DONE: begin
                    if (head_q == IDX_W'(i)) st_d[i] = SLOT_FREE;
                end
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[i]  <= SLOT_FREE;
                tag_q[i] <= '0;
                bar_q[i] <= 1'b0;
            end else begin
                st_q[i] <= st_d[i];
                if (alloc_i && tail_q == IDX_W'(i)) begin
                    tag_q[i] <= alloc_tag_i;
                    bar_q[i] <= alloc_bar_i;
                end
            end
        end

        assign state_o[i] = st_q[i];
        assign tag_o[i]   = tag_q[i];
        assign bar_o[i]   = bar_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (pop)     head_q <= bump(head_q);
            if (alloc_i) tail_q <= bump(tail_q);
            cnt_q <= cnt_q + CNT_W'(alloc_i) - CNT_W'(pop);
        end
    end

    assign head_o  = head_q;
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign count_o = cnt_q;

endmodule

// File: rtl/lsq_order.sv
module lsq_order
    import lsq_pkg::*;
#(
    parameter int LQ_DEPTH = 8,
    parameter int SQ_DEPTH = 8,
    parameter int TAG_W    = 8,
    localparam int LQ_IW = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1,
    localparam int SQ_IW = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1
) (
    input  logic             no_alias_i,
    input  slot_state_e      lq_st_i  [LQ_DEPTH],
    input  logic [TAG_W-1:0] lq_tag_i [LQ_DEPTH],
    input  logic             lq_bar_i [LQ_DEPTH],
    input  logic [LQ_IW-1:0] lq_head_i,
    input  slot_state_e      sq_st_i  [SQ_DEPTH],
    input  logic [TAG_W-1:0] sq_tag_i [SQ_DEPTH],
    input  logic             sq_bar_i [SQ_DEPTH],
    input  logic [SQ_IW-1:0] sq_head_i,
    output logic             ld_pick_valid_o,
    output logic [LQ_IW-1:0] ld_pick_idx_o,
    output logic             st_pick_valid_o,
    output logic [SQ_IW-1:0] st_pick_idx_o,
    output logic             lq_bar_exec_o,
    output logic             sq_bar_exec_o
);

    logic [LQ_DEPTH-1:0] ld_rdy;
    logic [SQ_DEPTH-1:0] st_rdy;
    logic lq_twin, sq_twin, lq_hd_bar, sq_hd_bar, heads_pair;

    // a is older than b when the wrapped difference a-b is negative.
    function automatic logic older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
        logic [TAG_W-1:0] d;
        d = a - b;
        return d[TAG_W-1];
    endfunction

    // Load eligibility.
    always_comb begin
        for (int i = 0; i < LQ_DEPTH; i++) begin
            ld_rdy[i] = (lq_st_i[i] == SLOT_WAIT) && !lq_bar_i[i];
            for (int j = 0; j < LQ_DEPTH; j++) begin
                if (lq_st_i[j] == SLOT_WAIT && lq_bar_i[j] && older(lq_tag_i[j], lq_tag_i[i]))
                    ld_rdy[i] = 1'b0;
            end
            for (int s = 0; s < SQ_DEPTH; s++) begin
                if (sq_st_i[s] == SLOT_WAIT && older(sq_tag_i[s], lq_tag_i[i])) begin
                    if (!sq_bar_i[s] && !no_alias_i) ld_rdy[i] = 1'b0;
                    for (int j = 0; j < LQ_DEPTH; j++) begin
                        if (lq_st_i[j] == SLOT_WAIT && !lq_bar_i[j] &&
                            older(lq_tag_i[j], sq_tag_i[s]))
                            ld_rdy[i] = 1'b0;
                    end
                end
            end
        end
    end

    // Store eligibility.
    always_comb begin
        for (int s = 0; s < SQ_DEPTH; s++) begin
            st_rdy[s] = (sq_st_i[s] == SLOT_WAIT) && !sq_bar_i[s];
            for (int t = 0; t < SQ_DEPTH; t++) begin
                if (sq_st_i[t] == SLOT_WAIT && older(sq_tag_i[t], sq_tag_i[s]))
                    st_rdy[s] = 1'b0;
            end
            for (int j = 0; j < LQ_DEPTH; j++) begin
                if (lq_st_i[j] == SLOT_WAIT && !lq_bar_i[j] && older(lq_tag_i[j], sq_tag_i[s]))
                    st_rdy[s] = 1'b0;
            end
        end
    end

    // Oldest-first pick, scanning from each head.
    always_comb begin
        ld_pick_valid_o = 1'b0;
        ld_pick_idx_o   = '0;
        for (int k = 0; k < LQ_DEPTH; k++) begin
            int p;
            p = int'(lq_head_i) + k;
            if (p >= LQ_DEPTH) p = p - LQ_DEPTH;
            if (!ld_pick_valid_o && ld_rdy[p]) begin
                ld_pick_valid_o = 1'b1;
                ld_pick_idx_o   = LQ_IW'(p);
            end
        end
    end

    always_comb begin
        st_pick_valid_o = 1'b0;
        st_pick_idx_o   = '0;
        for (int k = 0; k < SQ_DEPTH; k++) begin
            int p;
            p = int'(sq_head_i) + k;
            if (p >= SQ_DEPTH) p = p - SQ_DEPTH;
            if (!st_pick_valid_o && st_rdy[p]) begin
                st_pick_valid_o = 1'b1;
                st_pick_idx_o   = SQ_IW'(p);
            end
        end
    end

    // Barrier retirement at the heads; the halves of a full barrier go together.
    always_comb begin
        lq_twin = 1'b0;
        sq_twin = 1'b0;
        for (int s = 0; s < SQ_DEPTH; s++) begin
            if (sq_st_i[s] != SLOT_FREE && sq_bar_i[s] && sq_tag_i[s] == lq_tag_i[lq_head_i])
                lq_twin = 1'b1;
        end
        for (int j = 0; j < LQ_DEPTH; j++) begin
            if (lq_st_i[j] != SLOT_FREE && lq_bar_i[j] && lq_tag_i[j] == sq_tag_i[sq_head_i])
                sq_twin = 1'b1;
        end
        lq_hd_bar  = (lq_st_i[lq_head_i] == SLOT_WAIT) && lq_bar_i[lq_head_i];
        sq_hd_bar  = (sq_st_i[sq_head_i] == SLOT_WAIT) && sq_bar_i[sq_head_i];
        heads_pair = lq_hd_bar && sq_hd_bar && (lq_tag_i[lq_head_i] == sq_tag_i[sq_head_i]);
        lq_bar_exec_o = lq_hd_bar && (!lq_twin || heads_pair);
        sq_bar_exec_o = sq_hd_bar && (!sq_twin || heads_pair);
    end

endmodule

// File: rtl/lsq_sched.sv
module lsq_sched
    import lsq_pkg::*;
#(
    parameter int LQ_DEPTH = 8,
    parameter int SQ_DEPTH = 8,
    parameter int TAG_W    = 8,
    localparam int LQ_IW = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1,
    localparam int SQ_IW = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1,
    localparam int LQ_CW = $clog2(LQ_DEPTH + 1),
    localparam int SQ_CW = $clog2(SQ_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             no_alias_en,
    input  logic             disp_valid,
    input  logic             disp_rd,
    input  logic             disp_wr,
    input  logic             disp_fx,
    output logic             disp_stall,
    output logic [TAG_W-1:0] disp_tag,
    output logic             ld_issue_valid,
    output logic [TAG_W-1:0] ld_issue_tag,
    output logic             st_issue_valid,
    output logic [TAG_W-1:0] st_issue_tag,
    input  logic             exec_valid,
    input  logic [TAG_W-1:0] exec_tag
);

    slot_state_e      lq_st  [LQ_DEPTH];
    logic [TAG_W-1:0] lq_tag [LQ_DEPTH];
    logic             lq_bar [LQ_DEPTH];
    logic [LQ_IW-1:0] lq_head;
    logic             lq_full;
    logic [LQ_CW-1:0] lq_count;

    slot_state_e      sq_st  [SQ_DEPTH];
    logic [TAG_W-1:0] sq_tag [SQ_DEPTH];
    logic             sq_bar [SQ_DEPTH];
    logic [SQ_IW-1:0] sq_head;
    logic             sq_full;
    logic [SQ_CW-1:0] sq_count;

    logic             ld_pick_valid, st_pick_valid;
    logic [LQ_IW-1:0] ld_pick_idx;
    logic [SQ_IW-1:0] st_pick_idx;
    logic             lq_bar_exec, sq_bar_exec;
    logic             disp_accept;
    logic [TAG_W-1:0] tag_q;

    assign disp_stall  = disp_valid && ((disp_rd && lq_full) || (disp_wr && sq_full));
    assign disp_accept = disp_valid && !disp_stall;
    assign disp_tag    = tag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           tag_q <= '0;
        else if (disp_accept) tag_q <= tag_q + 1'b1;
    end

    lsq_ring #(.DEPTH(LQ_DEPTH), .TAG_W(TAG_W)) u_lq (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (disp_accept && disp_rd),
        .alloc_tag_i (tag_q),
        .alloc_bar_i (disp_fx),
        .issue_i     (ld_pick_valid),
        .issue_idx_i (ld_pick_idx),
        .bar_exec_i  (lq_bar_exec),
        .cpl_i       (exec_valid),
        .cpl_tag_i   (exec_tag),
        .state_o     (lq_st),
        .tag_o       (lq_tag),
        .bar_o       (lq_bar),
        .head_o      (lq_head),
        .full_o      (lq_full),
        .count_o     (lq_count)
    );

    lsq_ring #(.DEPTH(SQ_DEPTH), .TAG_W(TAG_W)) u_sq (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (disp_accept && disp_wr),
        .alloc_tag_i (tag_q),
        .alloc_bar_i (disp_fx),
        .issue_i     (st_pick_valid),
        .issue_idx_i (st_pick_idx),
        .bar_exec_i  (sq_bar_exec),
        .cpl_i       (exec_valid),
        .cpl_tag_i   (exec_tag),
        .state_o     (sq_st),
        .tag_o       (sq_tag),
        .bar_o       (sq_bar),
        .head_o      (sq_head),
        .full_o      (sq_full),
        .count_o     (sq_count)
    );

    lsq_order #(.LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .TAG_W(TAG_W)) u_order (
        .no_alias_i      (no_alias_en),
        .lq_st_i         (lq_st),
        .lq_tag_i        (lq_tag),
        .lq_bar_i        (lq_bar),
        .lq_head_i       (lq_head),
        .sq_st_i         (sq_st),
        .sq_tag_i        (sq_tag),
        .sq_bar_i        (sq_bar),
        .sq_head_i       (sq_head),
        .ld_pick_valid_o (ld_pick_valid),
        .ld_pick_idx_o   (ld_pick_idx),
        .st_pick_valid_o (st_pick_valid),
        .st_pick_idx_o   (st_pick_idx),
        .lq_bar_exec_o   (lq_bar_exec),
        .sq_bar_exec_o   (sq_bar_exec)
    );

    assign ld_issue_valid = ld_pick_valid;
    assign ld_issue_tag   = ld_pick_valid ? lq_tag[ld_pick_idx] : '0;
    assign st_issue_valid = st_pick_valid;
    assign st_issue_tag   = st_pick_valid ? sq_tag[st_pick_idx] : '0;

endmodule

// File: rtl/lsq_sched_chk.sv
module lsq_sched_chk #(
    parameter int LQ_DEPTH = 8,
    parameter int SQ_DEPTH = 8,
    parameter int TAG_W    = 8,
    localparam int LQ_CW = $clog2(LQ_DEPTH + 1),
    localparam int SQ_CW = $clog2(SQ_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid,
    input logic             disp_stall,
    input logic [TAG_W-1:0] disp_tag,
    input logic             ld_issue_valid,
    input logic [TAG_W-1:0] ld_issue_tag,
    input logic             st_issue_valid,
    input logic [TAG_W-1:0] st_issue_tag,
    input logic [LQ_CW-1:0] lq_count,
    input logic [SQ_CW-1:0] sq_count
);

    AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_valid |-> !disp_stall); // R2

    AST_STALL_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_stall) |=> disp_tag == $past(disp_tag)); // R2

    AST_STALL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_stall) |=> (lq_count <= $past(lq_count) && sq_count <= $past(sq_count))); // R2

    AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_stall) |=> disp_tag == TAG_W'($past(disp_tag) + 1'b1)); // R12

    AST_LD_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_issue_valid |=> !(ld_issue_valid && ld_issue_tag == $past(ld_issue_tag))); // R10

    AST_ST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        st_issue_valid |=> !(st_issue_valid && st_issue_tag == $past(st_issue_tag))); // R10

    AST_LQ_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lq_count) <= int'($past(lq_count)) + 1) && (int'(lq_count) + 1 >= int'($past(lq_count)))); // R11

    AST_SQ_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sq_count) <= int'($past(sq_count)) + 1) && (int'(sq_count) + 1 >= int'($past(sq_count)))); // R11

endmodule

bind lsq_sched lsq_sched_chk #(
    .LQ_DEPTH (LQ_DEPTH),
    .SQ_DEPTH (SQ_DEPTH),
    .TAG_W    (TAG_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .disp_valid     (disp_valid),
    .disp_stall     (disp_stall),
    .disp_tag       (disp_tag),
    .ld_issue_valid (ld_issue_valid),
    .ld_issue_tag   (ld_issue_tag),
    .st_issue_valid (st_issue_valid),
    .st_issue_tag   (st_issue_tag),
    .lq_count       (lq_count),
    .sq_count       (sq_count)
);

// File: tb/tb_lsq_sched.sv
module tb_lsq_sched;

    localparam int LQ    = 4;
    localparam int SQ    = 3;
    localparam int TAG_W = 6;
    localparam int TMASK = (1 << TAG_W) - 1;
    localparam int M_WAIT = 1;
    localparam int M_ISS  = 2;
    localparam int M_DONE = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             no_alias_en = 1'b0;
    logic             disp_valid = 1'b0, disp_rd = 1'b0, disp_wr = 1'b0, disp_fx = 1'b0;
    logic             disp_stall;
    logic [TAG_W-1:0] disp_tag;
    logic             ld_issue_valid, st_issue_valid;
    logic [TAG_W-1:0] ld_issue_tag, st_issue_tag;
    logic             exec_valid = 1'b0;
    logic [TAG_W-1:0] exec_tag = '0;

    always #10 clk = ~clk;

    lsq_sched #(.LQ_DEPTH(LQ), .SQ_DEPTH(SQ), .TAG_W(TAG_W)) dut (
        .clk(clk), .rst_n(rst_n), .no_alias_en(no_alias_en),
        .disp_valid(disp_valid), .disp_rd(disp_rd), .disp_wr(disp_wr), .disp_fx(disp_fx),
        .disp_stall(disp_stall), .disp_tag(disp_tag),
        .ld_issue_valid(ld_issue_valid), .ld_issue_tag(ld_issue_tag),
        .st_issue_valid(st_issue_valid), .st_issue_tag(st_issue_tag),
        .exec_valid(exec_valid), .exec_tag(exec_tag)
    );

    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";
    bit    cur_na = 1'b0;

    // Reference model: queue 0 holds loads, queue 1 stores; index 0 is oldest.
    int m_tag [2][8];
    bit m_bar [2][8];
    int m_st  [2][8];
    int mn    [2];
    int next_tag = 0;
    logic [31:0] rs = 32'h1234_abcd;

    function automatic int rnd(input int n);
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return int'(rs % 32'(n));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_ld_ok(input int i);
        if (m_st[0][i] != M_WAIT || m_bar[0][i]) return 1'b0;
        for (int j = 0; j < mn[0]; j++)
            if (m_st[0][j] == M_WAIT && m_bar[0][j] && m_tag[0][j] < m_tag[0][i]) return 1'b0;
        for (int s = 0; s < mn[1]; s++) begin
            if (m_st[1][s] == M_WAIT && m_tag[1][s] < m_tag[0][i]) begin
                if (!m_bar[1][s] && !cur_na) return 1'b0;
                for (int j = 0; j < mn[0]; j++)
                    if (m_st[0][j] == M_WAIT && !m_bar[0][j] && m_tag[0][j] < m_tag[1][s]) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    function automatic bit m_st_ok(input int s);
        if (m_st[1][s] != M_WAIT || m_bar[1][s]) return 1'b0;
        for (int t = 0; t < mn[1]; t++)
            if (m_st[1][t] == M_WAIT && m_tag[1][t] < m_tag[1][s]) return 1'b0;
        for (int j = 0; j < mn[0]; j++)
            if (m_st[0][j] == M_WAIT && !m_bar[0][j] && m_tag[0][j] < m_tag[1][s]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int m_pick(input int q);
        for (int i = 0; i < mn[q]; i++)
            if ((q == 0) ? m_ld_ok(i) : m_st_ok(i)) return i;
        return -1;
    endfunction

    function automatic bit m_bar_exec(input int q);
        int o;
        bit twin;
        o = 1 - q;
        if (mn[q] == 0 || m_st[q][0] != M_WAIT || !m_bar[q][0]) return 1'b0;
        twin = 1'b0;
        for (int k = 0; k < mn[o]; k++)
            if (m_bar[o][k] && m_tag[o][k] == m_tag[q][0]) twin = 1'b1;
        if (!twin) return 1'b1;
        return (m_tag[o][0] == m_tag[q][0]) && m_st[o][0] == M_WAIT;
    endfunction

    task automatic step(input bit v, input bit rd, input bit wr, input bit fx,
                        input bit ev, input int etag);
        int  pk [2];
        bit  bx [2];
        bit  pp [2];
        bit  exp_stall;
        @(negedge clk);
        disp_valid = v; disp_rd = rd; disp_wr = wr; disp_fx = fx;
        no_alias_en = cur_na; exec_valid = ev; exec_tag = TAG_W'(etag & TMASK);
        #1;
        exp_stall = v && ((rd && mn[0] == LQ) || (wr && mn[1] == SQ));
        chk(disp_stall === exp_stall, "R2", int'(disp_stall), int'(exp_stall));
        chk(disp_tag === TAG_W'(next_tag & TMASK), "R12", int'(disp_tag), next_tag & TMASK);
        pk[0] = m_pick(0);
        pk[1] = m_pick(1);
        chk(ld_issue_valid === (pk[0] >= 0), cur_req, int'(ld_issue_valid), int'(pk[0] >= 0));
        if (pk[0] >= 0)
            chk(ld_issue_tag === TAG_W'(m_tag[0][pk[0]] & TMASK), cur_req,
                int'(ld_issue_tag), m_tag[0][pk[0]] & TMASK);
        chk(st_issue_valid === (pk[1] >= 0), cur_req, int'(st_issue_valid), int'(pk[1] >= 0));
        if (pk[1] >= 0)
            chk(st_issue_tag === TAG_W'(m_tag[1][pk[1]] & TMASK), cur_req,
                int'(st_issue_tag), m_tag[1][pk[1]] & TMASK);
        // next state of the model, all from the state before the edge
        for (int q = 0; q < 2; q++) begin
            bx[q] = m_bar_exec(q);
            pp[q] = (mn[q] > 0) && (m_st[q][0] == M_DONE);
        end
        for (int q = 0; q < 2; q++) begin
            if (ev)
                for (int k = 0; k < mn[q]; k++)
                    if (m_st[q][k] == M_ISS && m_tag[q][k] == etag) m_st[q][k] = M_DONE;
            if (pk[q] >= 0) m_st[q][pk[q]] = M_ISS;
            if (bx[q]) m_st[q][0] = M_DONE;
            if (pp[q]) begin
                for (int k = 1; k < mn[q]; k++) begin
                    m_tag[q][k-1] = m_tag[q][k];
                    m_bar[q][k-1] = m_bar[q][k];
                    m_st[q][k-1]  = m_st[q][k];
                end
                mn[q]--;
            end
        end
        if (v && !exp_stall) begin
            if (rd) begin
                m_tag[0][mn[0]] = next_tag; m_bar[0][mn[0]] = fx; m_st[0][mn[0]] = M_WAIT; mn[0]++;
            end
            if (wr) begin
                m_tag[1][mn[1]] = next_tag; m_bar[1][mn[1]] = fx; m_st[1][mn[1]] = M_WAIT; mn[1]++;
            end
            next_tag++;
        end
    endtask

    function automatic int oldest_live();
        int o;
        o = next_tag;
        for (int q = 0; q < 2; q++)
            if (mn[q] > 0 && m_tag[q][0] < o) o = m_tag[q][0];
        return o;
    endfunction

    task automatic run_phase(input string lbl, input bit na, input int mix, input int n,
                             input int pdisp, input int pcpl);
        cur_req = lbl;
        cur_na = na;
        for (int c = 0; c < n; c++) begin
            bit v, rd, wr, fx, ev;
            int etag, nis, pick, r;
            v = (rnd(100) < pdisp) && (next_tag - oldest_live() < 24);
            r = rnd(32);
            case (mix)
                0: begin rd = 1'b1; wr = 1'b0; fx = (r % 4 == 0); end
                1: begin rd = 1'b0; wr = 1'b1; fx = (r % 4 == 0); end
                2: begin rd = r[0]; wr = r[1]; fx = (r[4:2] == 3'd0); end
                default: begin rd = r[0]; wr = r[1]; fx = r[2]; end
            endcase
            nis = 0;
            for (int q = 0; q < 2; q++)
                for (int k = 0; k < mn[q]; k++) if (m_st[q][k] == M_ISS) nis++;
            ev = 1'b0;
            etag = 0;
            if (nis > 0 && rnd(100) < pcpl) begin
                pick = rnd(nis);
                for (int q = 0; q < 2; q++)
                    for (int k = 0; k < mn[q]; k++)
                        if (m_st[q][k] == M_ISS) begin
                            if (pick == 0) begin ev = 1'b1; etag = m_tag[q][k]; end
                            pick--;
                        end
            end else if (rnd(16) == 0) begin
                ev = 1'b1;
                etag = next_tag + 5;   // R11: matches no issued entry
            end
            step(v, rd, wr, fx, ev, etag);
        end
    endtask

    initial begin
        mn[0] = 0;
        mn[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle state straight after reset
        #1;
        chk(disp_stall === 1'b0, "R1", int'(disp_stall), 0);
        chk(ld_issue_valid === 1'b0, "R1", int'(ld_issue_valid), 0);
        chk(st_issue_valid === 1'b0, "R1", int'(st_issue_valid), 0);
        chk(disp_tag === '0, "R1", int'(disp_tag), 0);

        // R2: fill the load queue with no completions, then overrun it
        cur_req = "R2";
        cur_na = 1'b0;
        for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0);   // store still fits
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0);   // read-write needs the full load queue
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_phase("R11", 1'b0, 0, 60, 0, 100);

        for (int na = 0; na < 2; na++) begin
            for (int mix = 0; mix < 4; mix++) begin
                string lbl;
                if (na == 0) lbl = (mix == 0) ? "R3" : (mix == 1) ? "R5" : (mix == 2) ? "R6" : "R8";
                else         lbl = (mix == 0) ? "R9" : (mix == 1) ? "R10" : (mix == 2) ? "R7" : "R4";
                run_phase(lbl, na[0], mix, 400, 70, 25);
                run_phase(lbl, na[0], mix, 300, 90, 70);
                run_phase("R11", na[0], mix, 40, 0, 100);
            end
        end
        run_phase("R7", 1'b0, 2, 600, 60, 40);
        run_phase("R7", 1'b1, 2, 600, 60, 40);
        run_phase("R11", 1'b1, 3, 60, 0, 100);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule